// File: doc/BRIEF.md
# Byte-Serial Register-Mapped Packet Interface

This block is a small network interface that software drives entirely through a 32-bit synchronous register port. It holds one receive frame and one transmit frame, each up to `FRAME_MAX` bytes (1514 by default). Every byte of a frame moves through a single data register, one register access per byte. Count registers give the frame length, and a busy flag decides whether a new incoming frame may land. Received bytes arrive on a byte-wide valid/last/ready input. Transmitted frames leave on a byte-wide valid/last/ready output. A single level interrupt is raised while any interrupt-control flag is set.

Software acknowledges events one at a time through the interrupt-control register. Clearing transmit-done takes precedence over clearing receive-done, which in turn takes precedence over a soft reset. The soft reset is requested with the top bit and leaves that bit set as a test flag, which the next read of the register clears. Software opens the receiver by writing interrupt control once all flags are clear, because that write leaves busy low.

Top module: `bytenet_nic`

## Requirements
- R1: After hardware reset, busy reads 1, both counts read 0, interrupt control reads 0 and `irq` is low.
- R2: Only `reg_addr[5:0]` selects a register. 0x00 reads 0x4D495053 and 0x04 reads 0x4E455430. Busy is at 0x08 (bit 0), rx count at 0x0C, tx count at 0x10, interrupt control at 0x14, info at 0x18, rx data at 0x1C and tx data at 0x20. Info, tx data and every unmapped offset read 0.
- R3: Interrupt control bit 0 is tx done, bit 1 is rx done and bit 31 is the test flag. `irq` is high exactly while any of them is set.
- R4: A read of interrupt control returns its value, and the test flag is clear from the next cycle on.
- R5: A write to interrupt control takes exactly one action. If bit 0 is set, it clears tx done. Otherwise, if bit 1 is set, it clears rx done. Otherwise, if bit 31 is set, it performs a soft reset. A write of 0 changes no flag. After the write, busy equals "any flag set".
- R6: A soft reset clears both counts, both pointers and all flags, abandons any partial receive frame and sets busy to 1. It then sets the test flag, so interrupt control reads 0x80000000.
- R7: `rx_ready` rises only while busy is 0 and the rx count is below `FRAME_MAX`. It then stays high until the beat marked last. That beat loads the rx count with the frame length, rewinds the read pointer, and sets busy and rx done.
- R8: A read of rx data with a nonzero count returns the next stored byte, zero-extended, and decrements the count. With a count of 0 it returns 0 and changes nothing.
- R9: A write to tx count loads the value if it is at most `FRAME_MAX` and loads 0 otherwise. Either case rewinds the tx write pointer.
- R10: A tx data write stores bits 7:0. When the stored-byte total reaches the tx count, the frame is launched, both the count and the pointer clear, tx done is set and busy becomes 1.
- R11: A launched frame leaves on `tx_data` in write order, with `tx_valid` held and data stable until `tx_ready`, and `tx_last` marks only the final byte.
- R12: Received bytes beyond index `FRAME_MAX`-1 are dropped, and the rx count saturates at `FRAME_MAX`. A count of `FRAME_MAX` keeps `rx_ready` low even when busy is 0.
- R13: A tx data write is ignored while the tx count is 0, or while the previous frame is still leaving on the tx output.
- R14: When the last receive beat coincides with an interrupt-control write, the write is applied first and rx done and busy are then set. A soft reset in that cycle wins and drops the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| reg_addr | input | 8 | Register byte address (low 6 bits decoded) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects happen at the clock edge |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle `reg_rd` is high, else 0 |
| rx_data | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_last | input | 1 | Incoming byte ends the frame |
| rx_ready | output | 1 | Block accepts the incoming byte |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_last | output | 1 | Outgoing byte ends the frame |
| tx_ready | input | 1 | Sink accepts the outgoing byte |
| irq | output | 1 | Level interrupt, high while any interrupt-control flag is set |

## Verification
The end of a receive frame and a software write to interrupt control can land in the same clock cycle. Both change the flags and busy. The bench holds a partial frame open, then presents the last byte at the very edge where it writes interrupt control. It does this once with a rx-done acknowledge and once with a soft reset. It then judges the outcome by reading back interrupt control, busy and the rx count: the acknowledge must not hide the new rx done, and the soft reset must leave no trace of the frame.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;

    // Register offsets (low six address bits)
    localparam logic [5:0] OFF_ID0   = 6'h00;
    localparam logic [5:0] OFF_ID1   = 6'h04;
    localparam logic [5:0] OFF_BUSY  = 6'h08;
    localparam logic [5:0] OFF_RXCNT = 6'h0C;
    localparam logic [5:0] OFF_TXCNT = 6'h10;
    localparam logic [5:0] OFF_ICTL  = 6'h14;
    localparam logic [5:0] OFF_INFO  = 6'h18;
    localparam logic [5:0] OFF_RXDAT = 6'h1C;
    localparam logic [5:0] OFF_TXDAT = 6'h20;

    localparam logic [31:0] ID_WORD0 = 32'h4D49_5053;
    localparam logic [31:0] ID_WORD1 = 32'h4E45_5430;

    // Packed flag storage: index into the 3-bit flag vector
    localparam int FL_TX   = 0;
    localparam int FL_RX   = 1;
    localparam int FL_TEST = 2;

endpackage

// File: rtl/bytenet_bytemem.sv
module bytenet_bytemem #(
    parameter int DEPTH = 1514,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Asynchronous read: data register and stream output see the byte at once
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/bytenet_rdmux.sv
module bytenet_rdmux
    import bytenet_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic          rd,
    input  logic [5:0]    off,
    input  logic          busy,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] tx_cnt,
    input  logic [2:0]    flags,
    input  logic [7:0]    rx_byte,
    output logic [31:0]   rdata
);

    logic [31:0] sel;

    always_comb begin
        unique case (off)
            OFF_ID0:   sel = ID_WORD0;
            OFF_ID1:   sel = ID_WORD1;
            OFF_BUSY:  sel = {31'b0, busy};
            OFF_RXCNT: sel = 32'(rx_cnt);
            OFF_TXCNT: sel = 32'(tx_cnt);
            OFF_ICTL:  sel = {flags[FL_TEST], 29'b0, flags[FL_RX], flags[FL_TX]};
            OFF_RXDAT: sel = (rx_cnt != '0) ? {24'b0, rx_byte} : 32'b0;
            default:   sel = 32'b0;
        endcase
        rdata = rd ? sel : 32'b0;
    end

endmodule

// File: rtl/bytenet_nic.sv
module bytenet_nic
    import bytenet_pkg::*;
#(
    parameter int FRAME_MAX = 1514
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic        rx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        irq
);

    localparam int CW = $clog2(FRAME_MAX + 1);
    localparam int AW = $clog2(FRAME_MAX);
    localparam logic [CW-1:0] MAX_C = CW'(FRAME_MAX);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    typedef struct packed {
        logic          busy;
        logic [2:0]    flags;
        logic [CW-1:0] rx_cnt;
        logic [AW-1:0] rx_rd;
        logic [CW-1:0] rx_wr;
        logic          rx_act;
        logic [CW-1:0] tx_cnt;
        logic [CW-1:0] tx_wr;
        logic          snd_act;
        logic [CW-1:0] snd_len;
        logic [CW-1:0] snd_idx;
    } nic_state_t;

    nic_state_t q, d;

    logic [5:0] off;
    logic       unused_addr_hi;
    assign off            = reg_addr[5:0];
    assign unused_addr_hi = ^reg_addr[7:6];

    // Observable state, also seen by the bound checker
    logic          busy_w;
    logic [CW-1:0] rx_cnt_w;
    logic [2:0]    ictl_w;
    assign busy_w   = q.busy;
    assign rx_cnt_w = q.rx_cnt;
    assign ictl_w   = q.flags;

    // Event decode
    logic rx_beat, rx_end, rd_rx, rd_ictl, wr_ictl, soft_rst;
    logic wr_txc, txd_ok, tx_done, tx_beat, rx_we;
    logic [7:0] rx_rbyte, tx_rbyte;

    assign rx_ready = q.rx_act | (~q.busy & (q.rx_cnt < MAX_C));
    assign rx_beat  = rx_valid & rx_ready;
    assign rx_end   = rx_beat & rx_last;

    assign tx_valid = q.snd_act;
    assign tx_last  = q.snd_act & (q.snd_idx == (q.snd_len - ONE_C));
    assign tx_data  = tx_rbyte;
    assign tx_beat  = tx_valid & tx_ready;

    assign rd_rx    = reg_rd & (off == OFF_RXDAT) & (q.rx_cnt != '0);
    assign rd_ictl  = reg_rd & (off == OFF_ICTL);
    assign wr_ictl  = reg_wr & (off == OFF_ICTL);
    assign soft_rst = wr_ictl & ~reg_wdata[0] & ~reg_wdata[1] & reg_wdata[31];
    assign wr_txc   = reg_wr & (off == OFF_TXCNT);
    assign txd_ok   = reg_wr & (off == OFF_TXDAT) & (q.tx_cnt != '0)
                    & (q.tx_wr < q.tx_cnt) & ~q.snd_act;
    assign tx_done  = txd_ok & ((q.tx_wr + ONE_C) == q.tx_cnt);
    assign rx_we    = rx_beat & (q.rx_wr < MAX_C) & ~soft_rst;

    always_comb begin
        d = q;

        // Outgoing stream
        if (tx_beat) begin
            if (tx_last) begin
                d.snd_act = 1'b0;
                d.snd_idx = '0;
            end else begin
                d.snd_idx = q.snd_idx + ONE_C;
            end
        end

        // Register reads with side effects
        if (rd_rx) begin
            d.rx_cnt = q.rx_cnt - ONE_C;
            d.rx_rd  = q.rx_rd + AW'(1);
        end
        if (rd_ictl) begin
            d.flags[FL_TEST] = 1'b0;
        end

        // Transmit side
        if (wr_txc) begin
            d.tx_cnt = (reg_wdata <= 32'(FRAME_MAX)) ? reg_wdata[CW-1:0] : '0;
            d.tx_wr  = '0;
        end
        if (txd_ok) begin
            d.tx_wr = q.tx_wr + ONE_C;
            if (tx_done) begin
                d.tx_cnt       = '0;
                d.tx_wr        = '0;
                d.flags[FL_TX] = 1'b1;
                d.busy         = 1'b1;
                d.snd_act      = 1'b1;
                d.snd_len      = q.tx_cnt;
                d.snd_idx      = '0;
            end
        end

        // Interrupt acknowledge: one action, fixed priority
        if (wr_ictl) begin
            if (reg_wdata[0]) begin
                d.flags[FL_TX] = 1'b0;
            end else if (reg_wdata[1]) begin
                d.flags[FL_RX] = 1'b0;
            end
            d.busy = |d.flags;
        end

        // Receive side, applied after the acknowledge
        if (rx_beat) begin
            if (rx_last) begin
                d.rx_cnt       = (q.rx_wr < MAX_C) ? (q.rx_wr + ONE_C) : MAX_C;
                d.rx_rd        = '0;
                d.rx_wr        = '0;
                d.rx_act       = 1'b0;
                d.busy         = 1'b1;
                d.flags[FL_RX] = 1'b1;
            end else begin
                d.rx_act = 1'b1;
                if (q.rx_wr < MAX_C) begin
                    d.rx_wr = q.rx_wr + ONE_C;
                end
            end
        end

        // Soft reset overrides everything except the outgoing stream
        if (soft_rst) begin
            d.busy    = 1'b1;
            d.rx_cnt  = '0;
            d.rx_rd   = '0;
            d.rx_wr   = '0;
            d.rx_act  = 1'b0;
            d.tx_cnt  = '0;
            d.tx_wr   = '0;
            d.flags   = 3'b100;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.busy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign irq = |ictl_w;

    bytenet_bytemem #(.DEPTH(FRAME_MAX), .AW(AW)) u_rxmem (
        .clk   (clk),
        .we    (rx_we),
        .waddr (q.rx_wr[AW-1:0]),
        .wdata (rx_data),
        .raddr (q.rx_rd),
        .rdata (rx_rbyte)
    );

    bytenet_bytemem #(.DEPTH(FRAME_MAX), .AW(AW)) u_txmem (
        .clk   (clk),
        .we    (txd_ok),
        .waddr (q.tx_wr[AW-1:0]),
        .wdata (reg_wdata[7:0]),
        .raddr (q.snd_idx[AW-1:0]),
        .rdata (tx_rbyte)
    );

    bytenet_rdmux #(.CW(CW)) u_rdmux (
        .rd      (reg_rd),
        .off     (off),
        .busy    (busy_w),
        .rx_cnt  (rx_cnt_w),
        .tx_cnt  (q.tx_cnt),
        .flags   (ictl_w),
        .rx_byte (rx_rbyte),
        .rdata   (reg_rdata)
    );

endmodule

// File: rtl/bytenet_nic_chk.sv
module bytenet_nic_chk
    import bytenet_pkg::*;
#(
    parameter int FRAME_MAX = 1514,
    parameter int CW        = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    off,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [31:0]   reg_wdata,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic          rx_last,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          busy_w,
    input logic [CW-1:0] rx_cnt_w,
    input logic [2:0]    ictl_w
);

    logic c_rx_end, c_soft, c_wr_ictl;
    assign c_rx_end  = rx_valid & rx_ready & rx_last;
    assign c_wr_ictl = reg_wr & (off == OFF_ICTL);
    assign c_soft    = c_wr_ictl & ~reg_wdata[0] & ~reg_wdata[1] & reg_wdata[31];

    // R7: completed frame raises busy and rx done
    p_rxend_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_rx_end && !c_soft) |=> (busy_w && ictl_w[1]));

    // R7: receiver only opens when idle and not full
    p_ready_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> (!busy_w && (rx_cnt_w < CW'(FRAME_MAX))));

    // R12: count never exceeds frame capacity
    p_rxcnt_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt_w <= CW'(FRAME_MAX));

    // R11: stalled output byte is held
    p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // R4: reading interrupt control drops the test flag
    p_testbit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && off == OFF_ICTL && !reg_wr) |=> !ictl_w[2]);

    // R5: zero write leaves the flags alone
    p_zero_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_ictl && reg_wdata == 32'b0 && !reg_rd && !c_rx_end) |=> $stable(ictl_w));

    // R5: busy follows the flags after an acknowledge
    p_ack_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr_ictl && !c_soft && !reg_rd && !c_rx_end) |=> (busy_w == (ictl_w != 3'b000)));

endmodule

bind bytenet_nic bytenet_nic_chk #(.FRAME_MAX(FRAME_MAX), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .off       (reg_addr[5:0]),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_last   (rx_last),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .busy_w    (busy_w),
    .rx_cnt_w  (rx_cnt_w),
    .ictl_w    (ictl_w)
);

// File: tb/test_bytenet_nic.sv
module test_bytenet_nic;

    localparam int FMAX = 1514;
    localparam logic [7:0] A_ID0 = 8'h00, A_ID1 = 8'h04, A_BUSY = 8'h08, A_RXC = 8'h0C,
                           A_TXC = 8'h10, A_ICTL = 8'h14, A_INFO = 8'h18,
                           A_RXD = 8'h1C, A_TXD = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bytenet_nic #(.FRAME_MAX(FMAX)) i_bytenet_nic (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata, .reg_rdata,
        .rx_data, .rx_valid, .rx_last, .rx_ready,
        .tx_data, .tx_valid, .tx_last, .tx_ready, .irq
    );

    // Transmit sink with a stall pattern
    logic [7:0] cap_b [0:4095];
    bit         cap_l [0:4095];
    int         cap_n = 0;
    int         rdy_cnt = 0;
    bit         hold_tx = 1'b0;

    always @(negedge clk) begin
        rdy_cnt = rdy_cnt + 1;
        tx_ready = !hold_tx && ((rdy_cnt % 3) != 2);
        if (tx_valid && tx_ready) begin
            cap_b[cap_n] = tx_data;
            cap_l[cap_n] = tx_last;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] rxb(input int seed, input int i);
        return 8'((seed * 7 + i * 13 + 1) & 255);
    endfunction

    task automatic rx_frame(input int len, input int seed, output int acc);
        acc = 0;
        for (int i = 0; i < len; i++) begin
            int guard;
            guard = 0;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rxb(seed, i); rx_last = (i == len - 1);
            #1;
            while (!rx_ready && guard < 20) begin
                @(negedge clk); #1; guard++;
            end
            if (!rx_ready) break;
            acc++;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int acc, base;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_BUSY, v); check("R1 busy", v, 1);
        rd(A_RXC, v);  check("R1 rxcnt", v, 0);
        rd(A_TXC, v);  check("R1 txcnt", v, 0);
        rd(A_ICTL, v); check("R1 ictl", v, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2: decode and constant registers
        rd(A_ID0, v);  check("R2 id0", v, 32'h4D495053);
        rd(A_ID1, v);  check("R2 id1", v, 32'h4E455430);
        rd(A_INFO, v); check("R2 info", v, 0);
        rd(A_TXD, v);  check("R2 txdata", v, 0);
        rd(8'h3C, v);  check("R2 unmapped", v, 0);
        rd(8'h44, v);  check("R2 alias", v, 32'h4E455430);
        rd(8'hC8, v);  check("R2 alias busy", v, 1);

        // R5: zero write opens the block
        wr(A_ICTL, 0);
        rd(A_BUSY, v); check("R5 zero write busy", v, 0);
        rd(A_ICTL, v); check("R5 zero write flags", v, 0);

        // R7 R8 R3: receive sweep
        for (int len = 1; len <= 8; len++) begin
            rx_frame(len, len, acc);
            check("R7 accepted", acc, len);
            rd(A_RXC, v);  check("R7 rxcnt", v, len);
            rd(A_ICTL, v); check("R3 rxdone flag", v, 2);
            check("R3 irq rx", {31'b0, irq}, 1);
            rd(A_BUSY, v); check("R7 busy", v, 1);
            #1 check("R7 ready closed", {31'b0, rx_ready}, 0);
            for (int i = 0; i < len; i++) begin
                rd(A_RXD, v); check("R8 rx byte", v, {24'b0, rxb(len, i)});
            end
            rd(A_RXC, v); check("R8 drained", v, 0);
            rd(A_RXD, v); check("R8 empty read", v, 0);
            rd(A_RXC, v); check("R8 empty read count", v, 0);
            wr(A_ICTL, 2);
            rd(A_BUSY, v); check("R5 ack busy", v, 0);
            check("R3 irq cleared", {31'b0, irq}, 0);
        end

        // R9: tx count clamp
        wr(A_TXC, FMAX + 1); rd(A_TXC, v); check("R9 over limit", v, 0);
        wr(A_TXC, FMAX);     rd(A_TXC, v); check("R9 at limit", v, FMAX);
        wr(A_TXC, 0);

        // R13: data write with count zero
        base = cap_n;
        wr(A_TXD, 32'h77);
        repeat (10) @(negedge clk);
        check("R13 no launch", cap_n - base, 0);
        rd(A_ICTL, v); check("R13 no txdone", v, 0);

        // R10 R11: transmit sweep
        for (int len = 1; len <= 8; len++) begin
            base = cap_n;
            wr(A_TXC, len);
            for (int i = 0; i < len; i++) wr(A_TXD, 32'hDEAD_BE00 | 32'((len * 17 + i * 5) & 255));
            rd(A_TXC, v);  check("R10 count cleared", v, 0);
            rd(A_ICTL, v); check("R10 txdone", v, 1);
            rd(A_BUSY, v); check("R10 busy", v, 1);
            repeat (40) @(negedge clk);
            check("R11 length", cap_n - base, len);
            for (int i = 0; i < len; i++) begin
                check("R11 byte", {24'b0, cap_b[base + i]}, 32'((len * 17 + i * 5) & 255));
                check("R11 last", {31'b0, cap_l[base + i]}, (i == len - 1) ? 1 : 0);
            end
            wr(A_ICTL, 1);
            rd(A_ICTL, v); check("R5 tx ack", v, 0);
        end

        // R13: writes ignored while a frame is still leaving
        hold_tx = 1'b1;
        base = cap_n;
        wr(A_TXC, 2); wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        wr(A_TXC, 2); wr(A_TXD, 32'h33);
        rd(A_TXC, v);  check("R13 busy stream ignored", v, 2);
        hold_tx = 1'b0;
        repeat (20) @(negedge clk);
        check("R13 first frame len", cap_n - base, 2);
        check("R13 byte0", {24'b0, cap_b[base]}, 32'h11);
        check("R13 byte1", {24'b0, cap_b[base + 1]}, 32'h22);
        base = cap_n;
        wr(A_TXD, 32'h44); wr(A_TXD, 32'h55);
        repeat (20) @(negedge clk);
        check("R13 second frame", {cap_b[base], cap_b[base + 1]}, 32'h4455);
        wr(A_ICTL, 1);

        // R5: priority with both flags set
        rx_frame(3, 40, acc);
        wr(A_TXC, 1); wr(A_TXD, 32'h5A);
        repeat (10) @(negedge clk);
        rd(A_ICTL, v); check("R5 both set", v, 3);
        wr(A_ICTL, 3);
        rd(A_ICTL, v); check("R5 priority tx first", v, 2);
        rd(A_BUSY, v); check("R5 busy stays", v, 1);
        wr(A_ICTL, 32'h8000_0002);
        rd(A_ICTL, v); check("R5 rx before test", v, 0);
        rd(A_RXC, v);  check("R5 no soft reset", v, 3);

        // R6 R4: soft reset and test flag
        wr(A_TXC, 5);
        wr(A_ICTL, 32'h8000_0000);
        check("R3 irq test", {31'b0, irq}, 1);
        rd(A_ICTL, v); check("R6 test flag", v, 32'h8000_0000);
        rd(A_ICTL, v); check("R4 cleared on read", v, 0);
        check("R4 irq low", {31'b0, irq}, 0);
        rd(A_TXC, v);  check("R6 txcnt", v, 0);
        rd(A_RXC, v);  check("R6 rxcnt", v, 0);
        rd(A_BUSY, v); check("R6 busy", v, 1);

        // R12: oversize frame
        wr(A_ICTL, 0);
        rx_frame(FMAX + 6, 9, acc);
        check("R12 all accepted", acc, FMAX + 6);
        rd(A_RXC, v);  check("R12 capped", v, FMAX);
        wr(A_ICTL, 2);
        rd(A_BUSY, v); check("R12 busy low", v, 0);
        #1 check("R12 full blocks", {31'b0, rx_ready}, 0);
        rd(A_RXD, v);  check("R12 first byte", v, {24'b0, rxb(9, 0)});
        #1 check("R7 reopens", {31'b0, rx_ready}, 1);
        wr(A_ICTL, 32'h8000_0000);
        rd(A_ICTL, v);
        wr(A_ICTL, 0);

        // R14: frame end with an acknowledge in the same cycle
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i + 3); rx_last = 1'b0;
        end
        @(negedge clk);
        rx_data = 8'h09; rx_last = 1'b1;
        reg_addr = A_ICTL; reg_wdata = 32'h2; reg_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; reg_wr = 1'b0;
        rd(A_ICTL, v); check("R14 rxdone survives", v, 2);
        rd(A_BUSY, v); check("R14 busy", v, 1);
        rd(A_RXC, v);  check("R14 count", v, 3);
        rd(A_RXD, v);  check("R14 data", v, 3);
        wr(A_ICTL, 2);

        // R14: soft reset wins over frame end
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i + 3); rx_last = 1'b0;
        end
        @(negedge clk);
        rx_last = 1'b1;
        reg_addr = A_ICTL; reg_wdata = 32'h8000_0000; reg_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; reg_wr = 1'b0;
        rd(A_ICTL, v); check("R14 soft wins flags", v, 32'h8000_0000);
        rd(A_RXC, v);  check("R14 soft wins count", v, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule